// File: doc/BRIEF.md
# Call/Return Stack with Interrupt Vectoring

This unit owns the program counter for a small processor core and moves it on subroutine calls, returns and hardware interrupts. A call saves the address of the following instruction on a last-in first-out stack and jumps to a target address. A return takes the newest saved address off the stack and resumes there. The decoder above this unit reports each retired instruction with a step strobe, and qualifies it with call, return or return-from-interrupt commands.

An interrupt works like a call that the hardware starts on its own. It is taken only at a plain instruction boundary, and the lowest-numbered pending request line wins. The handler address comes from a small writable vector table with one entry per request line. While a handler runs, further requests are masked, and return-from-interrupt lifts that mask. The stack has a fixed depth. A push into a full stack, or a pop from an empty one, is refused and reported on a one-cycle flag.

Top module: `pcflow_unit`

## Requirements
- R1: After reset, `pc_o` is 0x0000, `in_service_o`, `overflow_o` and `underflow_o` are 0, and the stack is empty.
- R2: A cycle with `step_i`=1 and no command (and no interrupt taken) sets `pc_o` to `pc_o`+1 modulo 2^16 on the next edge. With `step_i`=0, `pc_o` and the stack keep their values and all commands are ignored.
- R3: A call (`step_i`=1, `call_i`=1) on a non-full stack pushes `pc_o`+1 and sets `pc_o` to `target_i` on the next edge.
- R4: A return (`ret_i`) on a non-empty stack pops the newest entry into `pc_o`, so the addresses come back in last-in first-out order.
- R5: The stack holds DEPTH=8 entries. A call into a full stack raises `overflow_o` for exactly one cycle and leaves `pc_o` and the stack unchanged.
- R6: A return or return-from-interrupt on an empty stack raises `underflow_o` for exactly one cycle and leaves `pc_o`, the stack and `in_service_o` unchanged.
- R7: When several commands are present in one step, only one acts: call first, then return-from-interrupt, then return.
- R8: When a plain step sees a nonzero `irq_i`, `in_service_o`=0 and a non-full stack, the lowest set bit index i wins. The unit pushes `pc_o`+1, loads vector entry i into `pc_o` and sets `in_service_o`. While `in_service_o`=1, `irq_i` has no effect.
- R9: A successful return-from-interrupt (`reti_i`) restores `pc_o` from the stack and clears `in_service_o`. A plain return leaves `in_service_o` unchanged.
- R10: Vector entry i resets to 0x0040 + 0x0010*i. Setting `vec_we_i` writes `vec_data_i` into entry `vec_idx_i`. An interrupt taken in the same cycle as a write still uses the old value.
- R11: A request seen while the stack is full is not taken and raises no flag. The step advances `pc_o` by one, and the request can be taken at a later boundary once room exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | An instruction retires this cycle |
| call_i | input | 1 | Retiring instruction is a call |
| ret_i | input | 1 | Retiring instruction is a return |
| reti_i | input | 1 | Retiring instruction is a return-from-interrupt |
| target_i | input | 16 | Call destination |
| irq_i | input | NSRC (4) | Level interrupt requests, bit 0 highest priority |
| vec_we_i | input | 1 | Vector table write enable |
| vec_idx_i | input | clog2(NSRC) (2) | Vector entry to write |
| vec_data_i | input | 16 | Handler address to write |
| pc_o | output | 16 | Program counter |
| in_service_o | output | 1 | Interrupt mask, set while a handler runs |
| overflow_o | output | 1 | One-cycle pulse: call refused, stack full |
| underflow_o | output | 1 | One-cycle pulse: pop refused, stack empty |

## Verification
Every result of this unit lands one clock edge after the stimulus that caused it. This covers the new `pc_o`, the mask change, the vector write and the overflow or underflow pulse. The bench drives each stimulus on a falling edge. It advances its reference model for that single step, then compares all four outputs on the next falling edge, which falls after exactly one rising edge. The flags are compared in every cycle, so a pulse that lasts longer than one cycle or shows up in the wrong cycle fails the check.

// File: rtl/pcflow_pkg.sv
package pcflow_pkg;
  localparam int PC_W = 16;
  typedef logic [PC_W-1:0] pc_t;

  // address of the instruction after p, wrapping at the top of the space
  function automatic pc_t pc_next(input pc_t p);
    return p + pc_t'(1);
  endfunction

  // reset value of handler entry idx
  function automatic pc_t vec_default(input int unsigned idx);
    return pc_t'(32'h0040 + idx * 32'h0010);
  endfunction
endpackage

// File: rtl/pcf_stack.sv
module pcf_stack
  import pcflow_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic                       pop,
  input  pc_t                        wdata,
  output pc_t                        rdata,
  output logic                       full,
  output logic                       empty,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  pc_t            mem [DEPTH];
  logic [CW-1:0]  cnt_q;
  logic [AW-1:0]  wr_idx;
  logic [AW-1:0]  top_idx;

  assign wr_idx  = cnt_q[AW-1:0];
  assign top_idx = AW'(cnt_q - CW'(1));
  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign count   = cnt_q;
  assign rdata   = mem[top_idx];

  always_ff @(posedge clk) begin
    if (push && !full) mem[wr_idx] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (push && !full)    cnt_q <= cnt_q + CW'(1);
    else if (pop && !empty)    cnt_q <= cnt_q - CW'(1);
  end
endmodule

// File: rtl/pcf_vectors.sv
module pcf_vectors
  import pcflow_pkg::*;
#(
  parameter int NSRC = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              we,
  input  logic [((NSRC>1)?$clog2(NSRC):1)-1:0] widx,
  input  pc_t                               wdata,
  input  logic [((NSRC>1)?$clog2(NSRC):1)-1:0] ridx,
  output pc_t                               rdata
);
  pc_t vec_q [NSRC];

  assign rdata = vec_q[ridx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++) vec_q[i] <= vec_default(i);
    end else if (we) begin
      vec_q[widx] <= wdata;
    end
  end
endmodule

// File: rtl/pcf_pick.sv
module pcf_pick #(
  parameter int N = 4
) (
  input  logic [N-1:0]                     req,
  output logic                             valid,
  output logic [((N>1)?$clog2(N):1)-1:0]   idx,
  output logic [N-1:0]                     grant
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  always_comb begin
    idx   = '0;
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx   = IW'(i);
        grant = N'(1) << i;
      end
    end
    valid = |req;
  end
endmodule

// File: rtl/pcflow_unit.sv
module pcflow_unit
  import pcflow_pkg::*;
#(
  parameter int   DEPTH    = 8,
  parameter int   NSRC     = 4,
  parameter logic [15:0] RESET_PC = 16'h0000
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 step_i,
  input  logic                                 call_i,
  input  logic                                 ret_i,
  input  logic                                 reti_i,
  input  logic [15:0]                          target_i,
  input  logic [NSRC-1:0]                      irq_i,
  input  logic                                 vec_we_i,
  input  logic [((NSRC>1)?$clog2(NSRC):1)-1:0] vec_idx_i,
  input  logic [15:0]                          vec_data_i,
  output logic [15:0]                          pc_o,
  output logic                                 in_service_o,
  output logic                                 overflow_o,
  output logic                                 underflow_o
);
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  pc_t           pc_q;
  logic          mask_q, ovf_q, unf_q;
  pc_t           ret_addr, stk_top, vec_sel;
  logic          stk_full, stk_empty;
  logic [CW-1:0] stk_count;
  logic          irq_valid;
  logic [IW-1:0] irq_idx;
  logic [NSRC-1:0] irq_grant;

  // named internal events
  logic cmd_call, cmd_reti, cmd_ret, cmd_plain;
  logic ev_call, ev_ret_pop, ev_reti_pop, ev_irq_take;
  logic ev_push, ev_pop, ev_ovf, ev_unf;

  assign ret_addr = pc_next(pc_q);

  assign cmd_call  = step_i & call_i;
  assign cmd_reti  = step_i & ~call_i & reti_i;
  assign cmd_ret   = step_i & ~call_i & ~reti_i & ret_i;
  assign cmd_plain = step_i & ~call_i & ~reti_i & ~ret_i;

  assign ev_call     = cmd_call & ~stk_full;
  assign ev_ret_pop  = cmd_ret  & ~stk_empty;
  assign ev_reti_pop = cmd_reti & ~stk_empty;
  assign ev_irq_take = cmd_plain & irq_valid & ~mask_q & ~stk_full;
  assign ev_push     = ev_call | ev_irq_take;
  assign ev_pop      = ev_ret_pop | ev_reti_pop;
  assign ev_ovf      = cmd_call & stk_full;
  assign ev_unf      = (cmd_ret | cmd_reti) & stk_empty;

  pcf_pick #(.N(NSRC)) u_pick (
    .req   (irq_i),
    .valid (irq_valid),
    .idx   (irq_idx),
    .grant (irq_grant)
  );

  pcf_vectors #(.NSRC(NSRC)) u_vec (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (vec_we_i),
    .widx  (vec_idx_i),
    .wdata (vec_data_i),
    .ridx  (irq_idx),
    .rdata (vec_sel)
  );

  pcf_stack #(.DEPTH(DEPTH)) u_stack (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (ev_push),
    .pop   (ev_pop),
    .wdata (ret_addr),
    .rdata (stk_top),
    .full  (stk_full),
    .empty (stk_empty),
    .count (stk_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= pc_t'(RESET_PC);
      mask_q <= 1'b0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      ovf_q <= ev_ovf;
      unf_q <= ev_unf;
      if (ev_irq_take)          pc_q <= vec_sel;
      else if (ev_call)         pc_q <= target_i;
      else if (ev_pop)          pc_q <= stk_top;
      else if (cmd_plain)       pc_q <= ret_addr;
      if (ev_irq_take)          mask_q <= 1'b1;
      else if (ev_reti_pop)     mask_q <= 1'b0;
    end
  end

  assign pc_o         = pc_q;
  assign in_service_o = mask_q;
  assign overflow_o   = ovf_q;
  assign underflow_o  = unf_q;
endmodule

// File: rtl/pcflow_unit_chk.sv
module pcflow_unit_chk #(
  parameter int DEPTH = 8,
  parameter int NSRC  = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [15:0]                target_i,
  input logic [15:0]                pc_o,
  input logic                       in_service_o,
  input logic                       overflow_o,
  input logic                       underflow_o,
  input logic [$clog2(DEPTH+1)-1:0] stk_count,
  input logic                       stk_full,
  input logic                       ev_push,
  input logic                       ev_call,
  input logic                       ev_irq_take,
  input logic                       ev_reti_pop,
  input logic [NSRC-1:0]            irq_grant
);
  assert_depth_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stk_count <= ($clog2(DEPTH+1))'(DEPTH));

  assert_no_push_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stk_full |-> !ev_push);

  assert_ovf_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |-> (stk_full && pc_o == $past(pc_o)));

  assert_unf_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    underflow_o |-> (stk_count == '0 && pc_o == $past(pc_o)));

  assert_call_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_call |=> pc_o == $past(target_i));

  assert_irq_masks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_irq_take |=> in_service_o);

  assert_masked_no_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_service_o |-> !ev_irq_take);

  assert_one_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_grant));

  assert_mask_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_service_o && !ev_reti_pop) |=> in_service_o);

  assert_full_no_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    stk_full |-> !ev_irq_take);
endmodule

bind pcflow_unit pcflow_unit_chk #(.DEPTH(DEPTH), .NSRC(NSRC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .target_i     (target_i),
  .pc_o         (pc_o),
  .in_service_o (in_service_o),
  .overflow_o   (overflow_o),
  .underflow_o  (underflow_o),
  .stk_count    (stk_count),
  .stk_full     (stk_full),
  .ev_push      (ev_push),
  .ev_call      (ev_call),
  .ev_irq_take  (ev_irq_take),
  .ev_reti_pop  (ev_reti_pop),
  .irq_grant    (irq_grant)
);

// File: tb/pcflow_unit_bench.sv
`timescale 1ns/1ps
module pcflow_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;
  localparam int NSRC  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step_i = 0, call_i = 0, ret_i = 0, reti_i = 0;
  logic [15:0] target_i = '0;
  logic [3:0]  irq_i = '0;
  logic        vec_we_i = 0;
  logic [1:0]  vec_idx_i = '0;
  logic [15:0] vec_data_i = '0;
  logic [15:0] pc_o;
  logic        in_service_o, overflow_o, underflow_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // reference model
  logic [15:0] m_pc;
  logic [15:0] m_stk [DEPTH];
  int          m_cnt;
  bit          m_mask;
  logic [15:0] m_vec [NSRC];

  always #(CLK_PERIOD/2) clk = ~clk;

  pcflow_unit u_pcflow_unit (
    .clk(clk), .rst_n(rst_n), .step_i(step_i), .call_i(call_i), .ret_i(ret_i),
    .reti_i(reti_i), .target_i(target_i), .irq_i(irq_i), .vec_we_i(vec_we_i),
    .vec_idx_i(vec_idx_i), .vec_data_i(vec_data_i), .pc_o(pc_o),
    .in_service_o(in_service_o), .overflow_o(overflow_o), .underflow_o(underflow_o)
  );

  function automatic logic [15:0] exp_vec_reset(input int i);
    return 16'(64 + 16 * i);
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one cycle: drive at falling edge, model one step, compare at next falling edge
  task automatic cyc(input bit st, input bit c, input bit r, input bit ri,
                     input logic [15:0] tg, input logic [3:0] irq,
                     input bit we, input logic [1:0] wi, input logic [15:0] wd);
    string tag;
    bit e_ovf, e_unf;
    int win;
    step_i = st; call_i = c; ret_i = r; reti_i = ri; target_i = tg;
    irq_i = irq; vec_we_i = we; vec_idx_i = wi; vec_data_i = wd;
    tag = "R2"; e_ovf = 0; e_unf = 0; win = -1;
    if (st && c) begin
      if (m_cnt == DEPTH) begin e_ovf = 1; tag = "R5"; end
      else begin m_stk[m_cnt] = m_pc + 16'd1; m_cnt++; m_pc = tg; tag = "R3"; end
      if (r || ri) tag = "R7";
    end else if (st && (ri || r)) begin
      if (m_cnt == 0) begin e_unf = 1; tag = "R6"; end
      else begin
        m_cnt--; m_pc = m_stk[m_cnt];
        if (ri) m_mask = 0;
        tag = (ri || m_mask) ? "R9" : "R4";
      end
    end else if (st) begin
      for (int i = NSRC - 1; i >= 0; i--) if (irq[i]) win = i;
      if (win >= 0 && !m_mask && m_cnt < DEPTH) begin
        m_stk[m_cnt] = m_pc + 16'd1; m_cnt++; m_pc = m_vec[win]; m_mask = 1; tag = "R8";
      end else begin
        m_pc = m_pc + 16'd1;
        if (win >= 0 && !m_mask) tag = "R11";
        else if (win >= 0) tag = "R8";
      end
    end
    if (we) begin m_vec[wi] = wd; if (tag == "R2") tag = "R10"; end
    @(posedge clk);
    @(negedge clk);
    check(tag, "pc_o", pc_o, m_pc);
    check(tag, "in_service_o", {15'd0, in_service_o}, {15'd0, m_mask});
    check(e_ovf ? "R5" : tag, "overflow_o", {15'd0, overflow_o}, {15'd0, e_ovf});
    check(e_unf ? "R6" : tag, "underflow_o", {15'd0, underflow_o}, {15'd0, e_unf});
  endtask

  task automatic step(input bit c, input bit r, input bit ri, input logic [15:0] tg,
                      input logic [3:0] irq);
    cyc(1, c, r, ri, tg, irq, 0, 2'd0, 16'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    m_pc = 16'h0000; m_cnt = 0; m_mask = 0;
    for (int i = 0; i < NSRC; i++) m_vec[i] = exp_vec_reset(i);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "pc_o", pc_o, 16'h0000);
    check("R1", "in_service_o", {15'd0, in_service_o}, 16'h0);
    check("R1", "overflow_o", {15'd0, overflow_o}, 16'h0);
    check("R1", "underflow_o", {15'd0, underflow_o}, 16'h0);
    step(0, 1, 0, 16'h0, 4'h0);                 // R1/R6 empty stack after reset

    // R2 plain steps and idle
    step(0, 0, 0, 16'h0, 4'h0);
    step(0, 0, 0, 16'h0, 4'h0);
    cyc(0, 1, 0, 0, 16'h1234, 4'h1, 0, 2'd0, 16'h0);   // R2 no step: ignored
    // R3/R5 fill the stack, then overflow
    for (int k = 0; k < DEPTH; k++) step(1, 0, 0, 16'h1000 + 16'(k * 16'h100), 4'h0);
    step(1, 0, 0, 16'hBEEF, 4'h0);              // R5
    step(0, 0, 0, 16'h0, 4'b0110);              // R11 full, request held off
    // R4 unwind in LIFO order, then R6
    for (int k = 0; k < DEPTH; k++) step(0, 1, 0, 16'h0, 4'h0);
    step(0, 1, 0, 16'h0, 4'h0);                 // R6 ret on empty
    step(0, 0, 1, 16'h0, 4'h0);                 // R6 reti on empty
    // R10 vector write, R8 priority and masking
    cyc(1, 0, 0, 0, 16'h0, 4'h0, 1, 2'd2, 16'h2222);
    cyc(1, 0, 0, 0, 16'h0, 4'b0110, 1, 2'd1, 16'h7777); // R10 old vector used
    step(0, 0, 0, 16'h0, 4'b0001);              // R8 masked
    step(1, 0, 0, 16'h3000, 4'h0);
    step(0, 1, 0, 16'h0, 4'h0);                 // R9 ret keeps mask
    step(0, 0, 1, 16'h0, 4'h0);                 // R9 reti clears mask
    step(0, 0, 0, 16'h0, 4'b0100);              // R10 written vector
    // R7 command priority
    step(1, 1, 1, 16'h4000, 4'h0);              // call wins
    step(0, 1, 1, 16'h0, 4'h0);                 // reti wins over ret
    step(0, 1, 0, 16'h0, 4'h0);
    // R2 wrap
    step(1, 0, 0, 16'hFFFF, 4'h0);
    step(0, 0, 0, 16'h0, 4'h0);
    step(0, 1, 0, 16'h0, 4'h0);

    // constrained random
    void'($urandom(32'd1357));
    for (int n = 0; n < 4000; n++) begin
      bit st, c, r, ri, we;
      logic [3:0] irq;
      st  = ($urandom % 100) < 85;
      c   = ($urandom % 100) < 22;
      r   = ($urandom % 100) < 18;
      ri  = ($urandom % 100) < 10;
      irq = (($urandom % 100) < 20) ? 4'($urandom) : 4'h0;
      we  = ($urandom % 100) < 5;
      cyc(st, c, r, ri, 16'($urandom), irq, we, 2'($urandom), 16'($urandom));
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule